// File: doc/BRIEF.md
# Serial Pin Capture Scan Chain

This block is a plain serial scan chain for checking board connections. It is not an IEEE 1149.1 scan path: there is no TAP state machine, no instruction register and no update stage. A scan enable input puts the block in scan mode. A shift/capture select then decides what each scan clock edge does. On a capture edge every parallel pin level loads into the chain. On a shift edge the chain moves one place toward the serial output.

Pins leave the chain in a fixed order that is not linear. Exit position k carries pin index (EXIT_STRIDE*k + EXIT_OFFSET) mod N_BITS. The serial input at the tail of the chain is tied low, so after the last captured bit the output gives zeros for as long as shifting goes on. The serial output has an enable flag that stands in for a tri-state driver. While scan mode is on, the block raises an indication that tells the pin-mirroring logic to leave every pin in its normal place.

Top module: `pin_scan_chain`

## Requirements
- R1: A synchronous active-high reset clears every chain position to 0. With scan enabled and the output enabled, a shift edge just after reset gives 0 on `sout`.
- R2: With `scan_en`=1 and `shift_sel`=0, a rising `clk` edge loads all N_BITS pin levels. Right after that edge, and before any shift, `sout` shows exit position 0, which is pin (EXIT_OFFSET mod N_BITS). With the defaults that is pin 3.
- R3: With `scan_en`=1 and `shift_sel`=1, each rising edge moves the chain one place toward the output. After s shifts that follow a capture, `sout` shows pin (5*s+3) mod 67 for s from 0 to 66, using the defaults.
- R4: Once the last exit position has been shifted out, each further shift edge gives 0 on `sout`, because the tail of the chain is fed a constant 0.
- R5: While `scan_en`=0, the chain neither captures nor shifts, whatever `shift_sel` and `pins` do. When scan is enabled again, shifting carries on from the position that was held.
- R6: `sout_en` is 1 only when `scan_en`=1 and `oe_n`=0. While `sout_en`=0, `sout` reads 0. The chain still shifts while `oe_n`=1.
- R7: `remap_block` is 1 exactly while `scan_en`=1.
- R8: A capture edge in the middle of a shift sequence reloads every position from the current pin levels. Exit position 0 then shows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all chain state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan mode enable |
| shift_sel | input | 1 | 1 = shift toward output, 0 = capture pins |
| oe_n | input | 1 | Active-low serial output enable |
| pins | input | N_BITS | Parallel pin levels to capture |
| sout | output | 1 | Serial scan data, 0 when not enabled |
| sout_en | output | 1 | Serial output drive enable (tri-state model) |
| remap_block | output | 1 | Suppresses pin mirroring while scan is active |

## Verification
The assertions assume that `scan_en`, `shift_sel` and `oe_n` are stable around each rising scan clock edge and that reset is applied for at least one edge before the chain is checked. To meet this, the stimulus changes every control and every pin level only on the falling clock edge. It also holds reset across several rising edges at the start. The scoreboard takes each expected serial bit from the stated exit-order formula and from the known pin pattern, and never from the design's state.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_CAPTURE = 2'd1,
        CMD_SHIFT   = 2'd2
    } scan_cmd_e;

    typedef struct packed {
        logic data;
        logic drive;
        logic no_remap;
    } scan_out_t;

    // Pin index that occupies exit position pos.
    function automatic int exit_src(input int pos, input int n, input int stride, input int offset);
        return (pos * stride + offset) % n;
    endfunction

endpackage

// File: rtl/scan_cmd_decode.sv
module scan_cmd_decode
    import scan_pkg::*;
(
    input  logic      scan_en,
    input  logic      shift_sel,
    output scan_cmd_e cmd
);
    always_comb begin
        if (!scan_en)
            cmd = CMD_HOLD;
        else if (shift_sel)
            cmd = CMD_SHIFT;
        else
            cmd = CMD_CAPTURE;
    end
endmodule

// File: rtl/scan_chain_reg.sv
module scan_chain_reg
    import scan_pkg::*;
#(
    parameter int N_BITS      = 67,
    parameter int EXIT_STRIDE = 5,
    parameter int EXIT_OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_cmd_e         cmd,
    input  logic [N_BITS-1:0] pins,
    output logic [N_BITS-1:0] chain_q
);
    localparam int LAST = N_BITS - 1;

    for (genvar k = 0; k < N_BITS; k++) begin : g_cell
        localparam int SRC = exit_src(k, N_BITS, EXIT_STRIDE, EXIT_OFFSET);
        logic next_in;

        if (k == LAST) begin : g_tail
            assign next_in = 1'b0;
        end else begin : g_body
            assign next_in = chain_q[k+1];
        end

        always_ff @(posedge clk) begin
            if (rst)
                chain_q[k] <= 1'b0;
            else begin
                case (cmd)
                    CMD_CAPTURE: chain_q[k] <= pins[SRC];
                    CMD_SHIFT:   chain_q[k] <= next_in;
                    default:     chain_q[k] <= chain_q[k];
                endcase
            end
        end
    end
endmodule

// File: rtl/scan_out_stage.sv
module scan_out_stage
    import scan_pkg::*;
(
    input  logic      scan_en,
    input  logic      oe_n,
    input  logic      head_bit,
    output scan_out_t out
);
    always_comb begin
        out.drive    = scan_en & ~oe_n;
        out.data     = out.drive ? head_bit : 1'b0;
        out.no_remap = scan_en;
    end
endmodule

// File: rtl/pin_scan_chain.sv
module pin_scan_chain
    import scan_pkg::*;
#(
    parameter int N_BITS      = 67,
    parameter int EXIT_STRIDE = 5,
    parameter int EXIT_OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              shift_sel,
    input  logic              oe_n,
    input  logic [N_BITS-1:0] pins,
    output logic              sout,
    output logic              sout_en,
    output logic              remap_block
);
    scan_cmd_e         cmd;
    logic [N_BITS-1:0] chain_q;
    scan_out_t         out_s;

    scan_cmd_decode u_dec (
        .scan_en   (scan_en),
        .shift_sel (shift_sel),
        .cmd       (cmd)
    );

    scan_chain_reg #(
        .N_BITS      (N_BITS),
        .EXIT_STRIDE (EXIT_STRIDE),
        .EXIT_OFFSET (EXIT_OFFSET)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .pins    (pins),
        .chain_q (chain_q)
    );

    scan_out_stage u_out (
        .scan_en  (scan_en),
        .oe_n     (oe_n),
        .head_bit (chain_q[0]),
        .out      (out_s)
    );

    assign sout        = out_s.data;
    assign sout_en     = out_s.drive;
    assign remap_block = out_s.no_remap;
endmodule

// File: rtl/pin_scan_chain_chk.sv
module pin_scan_chain_chk #(
    parameter int N_BITS = 67
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_en,
    input logic              shift_sel,
    input logic              oe_n,
    input logic              sout,
    input logic              sout_en,
    input logic              remap_block,
    input logic [N_BITS-1:0] chain_q
);
    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (chain_q == '0));

    // R3
    assert_shift_moves_R3: assert property (@(posedge clk) disable iff (rst)
        (scan_en && shift_sel) |=> (chain_q[N_BITS-2:0] == $past(chain_q[N_BITS-1:1])));

    // R4
    assert_tail_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (scan_en && shift_sel) |=> (chain_q[N_BITS-1] == 1'b0));

    // R5
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(chain_q));

    // R6
    assert_quiet_output_R6: assert property (@(posedge clk) disable iff (rst)
        !sout_en |-> (sout == 1'b0));

    // R6
    assert_enable_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (oe_n || !scan_en) |-> !sout_en);

    // R7
    assert_remap_block_R7: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> remap_block);
endmodule

bind pin_scan_chain pin_scan_chain_chk #(.N_BITS(N_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scan_en     (scan_en),
    .shift_sel   (shift_sel),
    .oe_n        (oe_n),
    .sout        (sout),
    .sout_en     (sout_en),
    .remap_block (remap_block),
    .chain_q     (chain_q)
);

// File: tb/pin_scan_chain_tb.sv
module pin_scan_chain_tb;
    localparam int N = 67;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scan_en = 1'b0;
    logic         shift_sel = 1'b0;
    logic         oe_n = 1'b1;
    logic [N-1:0] pins = '0;
    logic         sout, sout_en, remap_block;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pin_scan_chain u_dut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .shift_sel(shift_sel),
        .oe_n(oe_n), .pins(pins), .sout(sout), .sout_en(sout_en),
        .remap_block(remap_block)
    );

    function automatic int src_of(input int pos);
        return (5 * pos + 3) % 67;
    endfunction

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares sout just after each rising edge with queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check1(t, sout, e);
            end
        end
    end

    // Driver: one clocked operation, with an optional expectation.
    task automatic step(input logic en, input logic sh, input logic oen,
                        input bit push, input bit e, input string req);
        @(negedge clk);
        scan_en = en; shift_sel = sh; oe_n = oen;
        if (push) begin
            exp_q.push_back(e);
            tag_q.push_back(req);
        end
    endtask

    task automatic capture(input logic [N-1:0] p, input string req);
        @(negedge clk);
        pins = p;
        scan_en = 1'b1; shift_sel = 1'b0; oe_n = 1'b0;
        exp_q.push_back(p[src_of(0)]);
        tag_q.push_back(req);
    endtask

    initial begin
        logic [N-1:0] pa, pb, pc;
        pa = {3'b101, 64'hA5C3_1E0F_9B27_64D8};
        pb = {3'b011, 64'h0123_4567_89AB_CDEF};
        pc = ~pa;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check1("R7 remap idle", remap_block, 1'b0);
        check1("R6 enable idle", sout_en, 1'b0);

        // R1: shift right after reset gives 0
        step(1, 1, 0, 1, 1'b0, "R1 reset content");
        step(1, 1, 0, 1, 1'b0, "R1 reset content");
        #1;
        check1("R7 remap active", remap_block, 1'b1);
        check1("R6 enable active", sout_en, 1'b1);

        // R2/R3/R4 full pass with pattern A
        capture(pa, "R2 first exit bit");
        for (int s = 1; s < N; s++)
            step(1, 1, 0, 1, pa[src_of(s)], "R3 exit order");
        for (int z = 0; z < 4; z++)
            step(1, 1, 0, 1, 1'b0, "R4 tail zeros");

        // R5: hold while scan disabled
        capture(pb, "R2 first exit bit B");
        for (int s = 1; s <= 10; s++)
            step(1, 1, 0, 1, pb[src_of(s)], "R3 exit order B");
        step(0, 1, 0, 0, 1'b0, "");
        #1;
        check1("R7 remap off", remap_block, 1'b0);
        check1("R6 enable off", sout_en, 1'b0);
        check1("R6 quiet sout", sout, 1'b0);
        step(0, 0, 0, 0, 1'b0, "");
        pins = pc;
        step(0, 1, 0, 0, 1'b0, "");
        step(0, 0, 0, 0, 1'b0, "");
        for (int s = 11; s <= 14; s++)
            step(1, 1, 0, 1, pb[src_of(s)], "R5 resume after hold");

        // R6: shifting continues with output disabled
        step(1, 1, 1, 1, 1'b0, "R6 gated sout");
        #1;
        check1("R6 enable oe_n high", sout_en, 1'b0);
        step(1, 1, 0, 1, pb[src_of(16)], "R6 chain advanced while gated");

        // R8: recapture mid-stream
        capture(pc, "R8 recapture");
        for (int s = 1; s <= 5; s++)
            step(1, 1, 0, 1, pc[src_of(s)], "R8 recapture order");

        step(0, 1, 1, 0, 1'b0, "");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule